// File: doc/BRIEF.md
# Dual-Lane Serial Register Loader

This block lets a microcontroller program five configuration registers over a slow synchronous serial bus. The bus has a serial clock, an active-low frame enable and two data lines, a main line and an auxiliary line. The block runs on a faster system clock and samples all four bus pins with it. A frame opens when enable falls and closes when enable rises. Each line sends a 3-bit register address first and then the data bits, most significant bit first. The addressed register is written only when the frame closes.

A frame may carry extra dummy bits between the address and the data, so hosts that always send 24 or 32 bits still work. The register keeps the last bits shifted in. Bit 9 of the control register picks single-lane or dual-lane operation. In dual-lane operation the auxiliary line carries its own address and data, so two registers load in one frame. The mode is sampled when a frame opens, so a change written in one frame applies from the next frame.

Top module: `serial_reg_loader`

## Requirements
- R1: While and after synchronous reset, all five register outputs are zero and dual-lane mode is off.
- R2: A line's first three bits after enable falls form the address, MSB first. The address codes are 000 control (13 bits), 001 receive ratio (16 bits), 010 transmit ratio (16 bits), 011 reference ratio (12 bits) and 100 auxiliary ratio (14 bits).
- R3: Bits between the address and the data are discarded. The register takes the last bits shifted before enable rises, right-aligned with the LSB sent last, so padded 24-bit and 32-bit frames load correctly.
- R4: A register changes only when enable rises. After all data bits have been shifted but before enable rises, the outputs still hold their old values.
- R5: A frame that closes after fewer than three serial clock rising edges writes no register.
- R6: A frame whose main-line address is 101, 110 or 111 writes no register.
- R7: When control bit 9 is 0 at frame start, the auxiliary line is ignored and only the main-line register is written.
- R8: A change of control bit 9 takes effect from the frame after the one that wrote it. This holds for both directions of the change.
- R9: When control bit 9 is 1 at frame start, the auxiliary line loads its own addressed register in the same frame. The shorter register's bits are padded after its address.
- R10: When both lines address the same register in a dual-lane frame, the main line's data is stored.
- R11: Serial clock edges while enable is high change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host; data is taken on its rising edge |
| sen_n | input | 1 | Active-low frame enable; its rising edge commits the frame |
| sdat | input | 1 | Main serial data line |
| sdat_aux | input | 1 | Auxiliary serial data line, used in dual-lane mode |
| ctrl_o | output | CTRL_W | Control register; bit MODE_BIT selects dual-lane mode |
| rx_o | output | RX_W | Receive loop ratio |
| tx_o | output | TX_W | Transmit loop ratio |
| ref_o | output | REF_W | Reference ratio |
| aux_o | output | AUXR_W | Auxiliary reference ratio |

## Verification
The bench builds the block with its default widths: 13, 16, 16, 12 and 14 bits, with the mode bit at position 9. With these widths, register widths differ inside one dual-lane frame, and a 32-bit padded frame carries more bits than the 16-bit shift stage holds. Frames of 2, 16, 17, 19, 24 and 32 bits exercise the short-frame, exact and padded cases. The control register is written both ways between modes, and each change is checked against the following frame.

// File: rtl/sload_pkg.sv
package sload_pkg;
  localparam int ADDR_W    = 3;
  localparam int LANES     = 2;
  localparam int REG_COUNT = 5;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_RX   = 3'd1,
    RA_TX   = 3'd2,
    RA_REF  = 3'd3,
    RA_AUX  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/sload_edges.sv
// Samples the bus pins in the system clock domain and derives event strobes.
module sload_edges #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             sen_n_i,
  input  logic [LANES-1:0] dat_i,
  output logic             bit_stb_o,
  output logic             start_o,
  output logic             commit_o,
  output logic [LANES-1:0] dat_o
);
  logic sclk_q1, sclk_q2, sen_q1, sen_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q1 <= 1'b0;
      sclk_q2 <= 1'b0;
      sen_q1  <= 1'b1;
      sen_q2  <= 1'b1;
      dat_o   <= '0;
    end else begin
      sclk_q1 <= sclk_i;
      sclk_q2 <= sclk_q1;
      sen_q1  <= sen_n_i;
      sen_q2  <= sen_q1;
      dat_o   <= dat_i;
    end
  end

  assign bit_stb_o = sclk_q1 & ~sclk_q2 & ~sen_q1;
  assign start_o   = ~sen_q1 & sen_q2;
  assign commit_o  = sen_q1 & ~sen_q2;
endmodule

// File: rtl/sload_lane.sv
// One data line: captures the address from the first bits, then keeps the newest data bits.
module sload_lane #(
  parameter int ADDR_W  = 3,
  parameter int SHIFT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               bit_stb_i,
  input  logic               din_i,
  output logic               addr_ok_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [SHIFT_W-1:0] data_o
);
  localparam int CNT_W = $clog2(ADDR_W + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      cnt_q  <= '0;
      addr_o <= '0;
      data_o <= '0;
    end else if (bit_stb_i) begin
      if (cnt_q < CNT_W'(ADDR_W)) begin
        addr_o <= {addr_o[ADDR_W-2:0], din_i};
        cnt_q  <= cnt_q + 1'b1;
      end else begin
        data_o <= {data_o[SHIFT_W-2:0], din_i};
      end
    end
  end

  assign addr_ok_o = (cnt_q == CNT_W'(ADDR_W));
endmodule

// File: rtl/sload_regs.sv
// Register bank: commits lane data into the addressed registers; main lane has priority.
module sload_regs import sload_pkg::*; #(
  parameter int CTRL_W  = 13,
  parameter int RX_W    = 16,
  parameter int TX_W    = 16,
  parameter int REF_W   = 12,
  parameter int AUXR_W  = 14,
  parameter int SHIFT_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           commit_i,
  input  logic                           quad_i,
  input  logic [LANES-1:0]               lane_ok_i,
  input  logic [LANES-1:0][ADDR_W-1:0]   lane_addr_i,
  input  logic [LANES-1:0][SHIFT_W-1:0]  lane_data_i,
  output logic [CTRL_W-1:0]              ctrl_o,
  output logic [RX_W-1:0]                rx_o,
  output logic [TX_W-1:0]                tx_o,
  output logic [REF_W-1:0]               ref_o,
  output logic [AUXR_W-1:0]              aux_o
);
  logic [REG_COUNT-1:0] hit_m, hit_a, we;

  for (genvar k = 0; k < REG_COUNT; k++) begin : g_hit
    assign hit_m[k] = commit_i & lane_ok_i[0] & (lane_addr_i[0] == ADDR_W'(k));
    assign hit_a[k] = commit_i & quad_i & lane_ok_i[1] &
                      (lane_addr_i[1] == ADDR_W'(k)) & ~hit_m[k];
    assign we[k]    = hit_m[k] | hit_a[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
      rx_o   <= '0;
      tx_o   <= '0;
      ref_o  <= '0;
      aux_o  <= '0;
    end else begin
      if (we[RA_CTRL]) ctrl_o <= CTRL_W'(hit_m[RA_CTRL] ? lane_data_i[0] : lane_data_i[1]);
      if (we[RA_RX])   rx_o   <= RX_W'(hit_m[RA_RX]     ? lane_data_i[0] : lane_data_i[1]);
      if (we[RA_TX])   tx_o   <= TX_W'(hit_m[RA_TX]     ? lane_data_i[0] : lane_data_i[1]);
      if (we[RA_REF])  ref_o  <= REF_W'(hit_m[RA_REF]   ? lane_data_i[0] : lane_data_i[1]);
      if (we[RA_AUX])  aux_o  <= AUXR_W'(hit_m[RA_AUX]  ? lane_data_i[0] : lane_data_i[1]);
    end
  end
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader import sload_pkg::*; #(
  parameter int CTRL_W   = 13,
  parameter int RX_W     = 16,
  parameter int TX_W     = 16,
  parameter int REF_W    = 12,
  parameter int AUXR_W   = 14,
  parameter int MODE_BIT = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sen_n,
  input  logic              sdat,
  input  logic              sdat_aux,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [RX_W-1:0]   rx_o,
  output logic [TX_W-1:0]   tx_o,
  output logic [REF_W-1:0]  ref_o,
  output logic [AUXR_W-1:0] aux_o
);
  localparam int W01     = (CTRL_W > RX_W) ? CTRL_W : RX_W;
  localparam int W23     = (TX_W > REF_W) ? TX_W : REF_W;
  localparam int W0123   = (W01 > W23) ? W01 : W23;
  localparam int SHIFT_W = (W0123 > AUXR_W) ? W0123 : AUXR_W;

  logic                          bit_stb, start, commit, quad_q;
  logic [LANES-1:0]              din;
  logic [LANES-1:0]              lane_ok;
  logic [LANES-1:0][ADDR_W-1:0]  lane_addr;
  logic [LANES-1:0][SHIFT_W-1:0] lane_data;

  sload_edges #(.LANES(LANES)) edges_i (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sen_n_i(sen_n),
    .dat_i({sdat_aux, sdat}), .bit_stb_o(bit_stb), .start_o(start),
    .commit_o(commit), .dat_o(din)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sload_lane #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) lane_i (
      .clk(clk), .rst(rst), .start_i(start), .bit_stb_i(bit_stb),
      .din_i(din[l]), .addr_ok_o(lane_ok[l]), .addr_o(lane_addr[l]),
      .data_o(lane_data[l])
    );
  end

  // Mode is frozen at frame start so a control write applies from the next frame.
  always_ff @(posedge clk) begin
    if (rst)        quad_q <= 1'b0;
    else if (start) quad_q <= ctrl_o[MODE_BIT];
  end

  sload_regs #(
    .CTRL_W(CTRL_W), .RX_W(RX_W), .TX_W(TX_W), .REF_W(REF_W),
    .AUXR_W(AUXR_W), .SHIFT_W(SHIFT_W)
  ) regs_i (
    .clk(clk), .rst(rst), .commit_i(commit), .quad_i(quad_q),
    .lane_ok_i(lane_ok), .lane_addr_i(lane_addr), .lane_data_i(lane_data),
    .ctrl_o(ctrl_o), .rx_o(rx_o), .tx_o(tx_o), .ref_o(ref_o), .aux_o(aux_o)
  );
endmodule

// File: rtl/sload_checker.sv
module sload_checker #(
  parameter int CTRL_W  = 13,
  parameter int RX_W    = 16,
  parameter int TX_W    = 16,
  parameter int REF_W   = 12,
  parameter int AUXR_W  = 14,
  parameter int SHIFT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    commit,
  input logic                    start,
  input logic                    quad_q,
  input logic [1:0]              lane_ok,
  input logic [1:0][2:0]         lane_addr,
  input logic [1:0][SHIFT_W-1:0] lane_data,
  input logic [CTRL_W-1:0]       ctrl_o,
  input logic [RX_W-1:0]         rx_o,
  input logic [TX_W-1:0]         tx_o,
  input logic [REF_W-1:0]        ref_o,
  input logic [AUXR_W-1:0]       aux_o
);
  // R4
  commit_only_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(ctrl_o) && $stable(rx_o) && $stable(tx_o) && $stable(ref_o) && $stable(aux_o));

  // R5
  short_frame_chk: assert property (@(posedge clk) disable iff (rst)
    commit && !lane_ok[0] && !quad_q |=>
      $stable(ctrl_o) && $stable(rx_o) && $stable(tx_o) && $stable(ref_o) && $stable(aux_o));

  // R6
  bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
    commit && lane_ok[0] && (lane_addr[0] > 3'd4) && !quad_q |=>
      $stable(ctrl_o) && $stable(rx_o) && $stable(tx_o) && $stable(ref_o) && $stable(aux_o));

  // R7
  single_lane_chk: assert property (@(posedge clk) disable iff (rst)
    commit && !quad_q && lane_ok[0] && (lane_addr[0] == 3'd1) |=>
      $stable(ctrl_o) && $stable(tx_o) && $stable(ref_o) && $stable(aux_o));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(quad_q));

  // R10
  main_wins_chk: assert property (@(posedge clk) disable iff (rst)
    commit && quad_q && (lane_ok == 2'b11) && (lane_addr[0] == 3'd1) && (lane_addr[1] == 3'd1) |=>
      rx_o == RX_W'($past(lane_data[0])));
endmodule

bind serial_reg_loader sload_checker #(
  .CTRL_W(CTRL_W), .RX_W(RX_W), .TX_W(TX_W), .REF_W(REF_W),
  .AUXR_W(AUXR_W), .SHIFT_W(SHIFT_W)
) chk_i (
  .clk(clk), .rst(rst), .commit(commit), .start(start), .quad_q(quad_q),
  .lane_ok(lane_ok), .lane_addr(lane_addr), .lane_data(lane_data),
  .ctrl_o(ctrl_o), .rx_o(rx_o), .tx_o(tx_o), .ref_o(ref_o), .aux_o(aux_o)
);

// File: tb/serial_reg_loader_tb_top.sv
module serial_reg_loader_tb_top;
  logic clk = 1'b0;
  logic rst, sclk, sen_n, sdat, sdat_aux;
  logic [12:0] ctrl_o;
  logic [15:0] rx_o, tx_o;
  logic [11:0] ref_o;
  logic [13:0] aux_o;

  always #2.5 clk = ~clk;

  serial_reg_loader dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .sen_n(sen_n), .sdat(sdat),
    .sdat_aux(sdat_aux), .ctrl_o(ctrl_o), .rx_o(rx_o), .tx_o(tx_o),
    .ref_o(ref_o), .aux_o(aux_o)
  );

  typedef struct {
    logic [12:0] c;
    logic [15:0] r;
    logic [15:0] t;
    logic [11:0] f;
    logic [13:0] a;
    string       tag;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  logic [12:0] m_ctrl = '0;
  logic [15:0] m_rx = '0, m_tx = '0;
  logic [11:0] m_ref = '0;
  logic [13:0] m_aux = '0;
  bit finished = 0;

  task automatic push(input string tag);
    exp_t e;
    e.c = m_ctrl; e.r = m_rx; e.t = m_tx; e.f = m_ref; e.a = m_aux; e.tag = tag;
    q.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp(input string tag, input string name, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  // Monitor: pops expected snapshots and compares them with the outputs.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "ctrl", 16'(ctrl_o), 16'(e.c));
        cmp(e.tag, "rx",   rx_o,        e.r);
        cmp(e.tag, "tx",   tx_o,        e.t);
        cmp(e.tag, "ref",  16'(ref_o),  16'(e.f));
        cmp(e.tag, "aux",  16'(aux_o),  16'(e.a));
      end
    end
  end

  task automatic model_wr(input logic [2:0] ad, input logic [15:0] d);
    case (ad)
      3'd0: m_ctrl = d[12:0];
      3'd1: m_rx   = d;
      3'd2: m_tx   = d;
      3'd3: m_ref  = d[11:0];
      3'd4: m_aux  = d[13:0];
      default: ;
    endcase
  endtask

  // Driver: sends n bits per line, MSB first, and predicts the register state.
  task automatic frame(input logic [31:0] m, input logic [31:0] a, input int n,
                       input bit peek, input string tag);
    logic q_mode;
    logic [2:0] am, aa;
    q_mode = m_ctrl[9];
    sen_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = m[i]; sdat_aux = a[i]; sclk = 1'b0;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (3) @(negedge clk);
    if (peek) push({tag, " R4 before enable rise"});
    sen_n = 1'b1;
    repeat (5) @(negedge clk);
    if (n >= 3) begin
      am = 3'(m >> (n - 3));
      aa = 3'(a >> (n - 3));
      model_wr(am, m[15:0]);
      if (q_mode && aa != am) model_wr(aa, a[15:0]);
    end
    push(tag);
  endtask

  initial begin
    rst = 1'b1; sclk = 1'b0; sen_n = 1'b1; sdat = 1'b0; sdat_aux = 1'b0;
    repeat (5) @(negedge clk);
    push("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    push("R1 after reset");
    // R2 control write, single-lane
    frame(32'({3'b000, 13'h0155}), 32'h0, 16, 0, "R2 ctrl");
    // R2 receive ratio
    frame(32'({3'b001, 16'hA5C3}), 32'h0, 19, 0, "R2 rx");
    // R3 32-bit frame padded with ones
    frame({3'b010, 13'h1FFF, 16'h1234}, 32'h0, 32, 0, "R3 tx 32-bit");
    // R3 24-bit frame for the reference ratio
    frame(32'({3'b011, 9'h1AB, 12'hABC}), 32'h0, 24, 0, "R3 ref 24-bit");
    // R2 auxiliary ratio
    frame(32'({3'b100, 14'h2D5A}), 32'h0, 17, 0, "R2 aux");
    // R4 peek before commit
    frame(32'({3'b001, 16'h0F0F}), 32'h0, 19, 1, "R4 rx");
    // R5 two-bit frame
    frame(32'b11, 32'b11, 2, 0, "R5 short");
    // R6 unused addresses
    frame(32'({3'b101, 16'hFFFF}), 32'h0, 19, 0, "R6 addr5");
    frame(32'({3'b111, 16'h1357}), 32'h0, 19, 0, "R6 addr7");
    // R7 aux line ignored in single-lane mode
    frame(32'({3'b001, 16'h4321}), 32'({3'b010, 16'hDEAD}), 19, 0, "R7 aux ignored");
    // R8 enable dual-lane; this frame still single-lane
    frame(32'({3'b000, 13'h020A}), 32'({3'b001, 13'h1ABC}), 16, 0, "R8 enter dual");
    // R9 dual-lane: rx on main, ref padded on aux
    frame(32'({3'b001, 16'h1111}), 32'({3'b011, 4'hF, 12'h777}), 19, 0, "R9 rx+ref");
    // R9 tx on main, aux ratio padded on aux
    frame(32'({3'b010, 16'hBEEF}), 32'({3'b100, 2'b10, 14'h1234}), 19, 0, "R9 tx+aux");
    // R10 same address on both lines
    frame(32'({3'b001, 16'h2222}), 32'({3'b001, 16'h3333}), 19, 0, "R10 collision");
    // R8 leave dual-lane; this frame still dual
    frame(32'({3'b000, 3'b000, 13'h0040}), 32'({3'b011, 4'h0, 12'h5A5}), 19, 0, "R8 leave dual");
    frame(32'({3'b010, 16'h7777}), 32'({3'b001, 16'h9999}), 19, 0, "R8 back single");
    // R11 clock toggles while idle
    for (int i = 0; i < 4; i++) begin
      sdat = i[0]; sdat_aux = ~i[0];
      sclk = 1'b1; repeat (3) @(negedge clk);
      sclk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    push("R11 idle clocks");
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule